// File: doc/BRIEF.md
# Line Access Switch State Controller

This block selects which of ten solid-state line switches are closed on a subscriber line card. A 3-bit command picks one of eight legal switch states. The command passes through a latch stage: while the latch enable is low the command flows through; while it is high the last command seen with the enable low is held. The registered state drives ten switch-enable outputs and a thermal-status flag.

Several protection conditions force every switch open, whatever the latch is doing. These are a supply lockout, a battery monitor with hysteresis, an external active-low shutdown pin and an internal thermal fault flag. After the supply returns, the switches stay open until the latch enable has been seen low. This lets a freshly inserted board stay off until its controller is ready. All inputs are synchronous flags, and every output changes one clock after the input that causes it.

The state machine has eight named states: ST_OFF, ST_TALK, ST_RING, ST_TOUT, ST_TIN, ST_TIN_TOUT, ST_GEN and ST_TOUT_GEN. On every clock it moves from any state to the state decoded from the effective command. The effective command is the live command when the latch is open and the held command when it is closed. The move to ST_OFF takes priority whenever a force condition is present.

Top module: `line_switch_ctrl`

## Requirements
- R1: Command codes select states as follows: 0 off, 1 talk, 2 ringing, 3 test-out, 4 test-in, 5 test-in plus test-out, 6 generator test, 7 test-out plus generator test. `sw_en_o[k]` drives switch k+1. The closed switches are: talk 1,2; ringing 3,4; test-out 5,6; generator test 7,8; test-in 9,10; test-in plus test-out 5,6,9,10; test-out plus generator test 5 to 8. The output reflects a command one clock after it is sampled.
- R2: In every cycle `sw_en_o` equals one of the eight masks listed in R1. No other switch combination ever appears.
- R3: While `latch_en_i` is 0, a change on `cmd_i` changes `sw_en_o` one clock later.
- R4: While `latch_en_i` is 1, the command in force is the one sampled at the last clock edge where `latch_en_i` was 0. Changes on `cmd_i` have no effect.
- R5: `therm_fault_i` high forces all switches open at the next edge, whatever the latch level. When it clears, the effective command applies again.
- R6: `tsd_n_i` low forces all switches open at the next edge, whatever the latch level.
- R7: While `supply_ok_i` is 0, all switches are open and the held command is cleared to 0. After the supply returns, all switches stay open until an edge where `supply_ok_i` is 1 and `latch_en_i` is 0.
- R8: If `supply_ok_i` returns while `latch_en_i` is already 0, the commanded state appears at that same edge.
- R9: `bat_hi_i` high marks the battery as lost and forces all switches open. The battery is marked good again only when `bat_lo_i` is high. With neither flag high, the last mark is kept. When both flags are high, `bat_hi_i` wins. After reset the battery is marked lost.
- R10: `therm_stat_o` is 0 in the cycle after `therm_fault_i` was high, and 1 otherwise. `tsd_n_i` has no effect on it.
- R11: When parameter `EN_TOUT_GEN` is 0, code 7 selects all-off. Its default is 1.
- R12: During and right after reset, `sw_en_o` is all zero and `therm_stat_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Switch state command |
| latch_en_i | input | 1 | 0 = command flows through, 1 = hold |
| supply_ok_i | input | 1 | Supply above valid threshold |
| bat_hi_i | input | 1 | Battery more positive than the loss threshold |
| bat_lo_i | input | 1 | Battery more negative than the restore threshold |
| therm_fault_i | input | 1 | Internal thermal shutdown active |
| tsd_n_i | input | 1 | External shutdown pin level, active low |
| sw_en_o | output | 10 | Switch enables, bit k closes switch k+1 |
| therm_stat_o | output | 1 | Thermal status, low during thermal shutdown |

## Verification
All eight codes are swept with the latch open. This separates the decode of each state, and running it on a second instance built with `EN_TOUT_GEN` at 0 shows the code-7 variant. Command changes are then applied with the latch closed, with faults asserted on top, and across supply drops with the enable high or low. These patterns separate a latch that holds from one that leaks, and an override that respects the latch from one that bypasses it. They also show a lockout that releases at the wrong moment. Battery flag pulses in all orders check that hysteresis keeps its state when neither flag is set. A long random phase mixes all inputs. It compares each output on every clock against a behavioural model and checks mask legality on override edges.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    localparam int CMD_W  = 3;
    localparam int NUM_SW = 10;

    typedef enum logic [CMD_W-1:0] {
        ST_OFF      = 3'd0,
        ST_TALK     = 3'd1,
        ST_RING     = 3'd2,
        ST_TOUT     = 3'd3,
        ST_TIN      = 3'd4,
        ST_TIN_TOUT = 3'd5,
        ST_GEN      = 3'd6,
        ST_TOUT_GEN = 3'd7
    } lsw_state_e;

    // Switch masks, bit k closes switch k+1.
    localparam logic [NUM_SW-1:0] M_TALK = 10'b00_0000_0011;
    localparam logic [NUM_SW-1:0] M_RING = 10'b00_0000_1100;
    localparam logic [NUM_SW-1:0] M_TOUT = 10'b00_0011_0000;
    localparam logic [NUM_SW-1:0] M_GEN  = 10'b00_1100_0000;
    localparam logic [NUM_SW-1:0] M_TIN  = 10'b11_0000_0000;

    function automatic logic lsw_legal(input logic [NUM_SW-1:0] m);
        return (m == '0) || (m == M_TALK) || (m == M_RING) ||
               (m == M_TOUT) || (m == M_GEN) || (m == M_TIN) ||
               (m == (M_TIN | M_TOUT)) || (m == (M_TOUT | M_GEN));
    endfunction

endpackage

// File: rtl/lsw_guard.sv
module lsw_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic latch_en_i,
    input  logic bat_hi_i,
    input  logic bat_lo_i,
    output logic blocked_o,
    output logic bat_ok_o
);

    logic lock_q;
    logic bat_q;

    // Lockout arms on a bad supply, disarms once the enable is seen low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            lock_q <= 1'b1;
        else if (!supply_ok_i) lock_q <= 1'b1;
        else if (!latch_en_i)  lock_q <= 1'b0;
    end

    // Battery hysteresis: loss flag wins, restore flag re-arms.
    assign bat_ok_o = bat_hi_i ? 1'b0 : (bat_lo_i ? 1'b1 : bat_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bat_q <= 1'b0;
        else        bat_q <= bat_ok_o;
    end

    assign blocked_o = !supply_ok_i || (lock_q && latch_en_i);

    // R7
    lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok_i && latch_en_i && !$past(supply_ok_i)) |-> blocked_o);

endmodule

// File: rtl/lsw_cmd_latch.sv
module lsw_cmd_latch #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch_en_i,
    input  logic         supply_ok_i,
    input  logic [W-1:0] cmd_i,
    output logic [W-1:0] eff_cmd_o
);

    logic [W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            held_q <= '0;
        else if (!supply_ok_i) held_q <= '0;
        else if (!latch_en_i)  held_q <= cmd_i;
    end

    assign eff_cmd_o = latch_en_i ? held_q : cmd_i;

    // R4
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en_i && supply_ok_i) |=> $stable(held_q));

endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
    import lsw_pkg::*;
#(
    parameter bit EN_TOUT_GEN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic              latch_en_i,
    input  logic              supply_ok_i,
    input  logic              bat_hi_i,
    input  logic              bat_lo_i,
    input  logic              therm_fault_i,
    input  logic              tsd_n_i,
    output logic [NUM_SW-1:0] sw_en_o,
    output logic              therm_stat_o
);

    lsw_state_e       state_q, state_d, code7_state;
    logic [CMD_W-1:0] eff_cmd;
    logic             blocked, bat_ok, force_off;
    logic             therm_stat_q;

    lsw_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok_i(supply_ok_i),
        .latch_en_i (latch_en_i),
        .bat_hi_i   (bat_hi_i),
        .bat_lo_i   (bat_lo_i),
        .blocked_o  (blocked),
        .bat_ok_o   (bat_ok)
    );

    lsw_cmd_latch #(.W(CMD_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_en_i (latch_en_i),
        .supply_ok_i(supply_ok_i),
        .cmd_i      (cmd_i),
        .eff_cmd_o  (eff_cmd)
    );

    generate
        if (EN_TOUT_GEN) begin : g_tout_gen
            assign code7_state = ST_TOUT_GEN;
        end else begin : g_no_tout_gen
            assign code7_state = ST_OFF;
        end
    endgenerate

    assign force_off = blocked || !bat_ok || therm_fault_i || !tsd_n_i;

    always_comb begin
        if (force_off) begin
            state_d = ST_OFF;
        end else begin
            unique case (eff_cmd)
                3'd0:    state_d = ST_OFF;
                3'd1:    state_d = ST_TALK;
                3'd2:    state_d = ST_RING;
                3'd3:    state_d = ST_TOUT;
                3'd4:    state_d = ST_TIN;
                3'd5:    state_d = ST_TIN_TOUT;
                3'd6:    state_d = ST_GEN;
                default: state_d = code7_state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_OFF;
            therm_stat_q <= 1'b1;
        end else begin
            state_q      <= state_d;
            therm_stat_q <= !therm_fault_i;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_OFF:      sw_en_o = '0;
            ST_TALK:     sw_en_o = M_TALK;
            ST_RING:     sw_en_o = M_RING;
            ST_TOUT:     sw_en_o = M_TOUT;
            ST_TIN:      sw_en_o = M_TIN;
            ST_TIN_TOUT: sw_en_o = M_TIN | M_TOUT;
            ST_GEN:      sw_en_o = M_GEN;
            ST_TOUT_GEN: sw_en_o = M_TOUT | M_GEN;
            default:     sw_en_o = '0;
        endcase
    end

    assign therm_stat_o = therm_stat_q;

    // R2
    legal_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsw_legal(sw_en_o));

    // R5
    therm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        therm_fault_i |=> (sw_en_o == '0));

    // R6
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tsd_n_i |=> (sw_en_o == '0));

    // R7
    supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (sw_en_o == '0));

    // R9
    bat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_hi_i |=> (sw_en_o == '0));

    // R10
    therm_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        therm_fault_i |=> !therm_stat_o);

endmodule

// File: tb/line_switch_ctrl_tb_top.sv
module line_switch_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic       latch = 1'b1, sup = 1'b0, bhi = 1'b0, blo = 1'b0;
    logic       tf = 1'b0, tsd_n = 1'b1;
    logic [9:0] sw_a, sw_b;
    logic       stat_a, stat_b;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R12";

    always #2.5 clk = ~clk;

    line_switch_ctrl #(.EN_TOUT_GEN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .latch_en_i(latch),
        .supply_ok_i(sup), .bat_hi_i(bhi), .bat_lo_i(blo),
        .therm_fault_i(tf), .tsd_n_i(tsd_n), .sw_en_o(sw_a), .therm_stat_o(stat_a));

    line_switch_ctrl #(.EN_TOUT_GEN(1'b0)) dut_nogen_i (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .latch_en_i(latch),
        .supply_ok_i(sup), .bat_hi_i(bhi), .bat_lo_i(blo),
        .therm_fault_i(tf), .tsd_n_i(tsd_n), .sw_en_o(sw_b), .therm_stat_o(stat_b));

    function automatic logic [9:0] mask_of(input int code, input bit gen7);
        case (code)
            1: return 10'h003;
            2: return 10'h00C;
            3: return 10'h030;
            4: return 10'h300;
            5: return 10'h330;
            6: return 10'h0C0;
            7: return gen7 ? 10'h0F0 : 10'h000;
            default: return 10'h000;
        endcase
    endfunction

    function automatic bit is_legal(input logic [9:0] m);
        for (int c = 0; c < 8; c++) if (m === mask_of(c, 1'b1)) return 1'b1;
        return 1'b0;
    endfunction

    // Behavioural reference
    bit         m_lock, m_bat, m_stat;
    int         m_held;
    logic [9:0] m_a, m_b;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lock = 1; m_bat = 0; m_held = 0; m_stat = 1; m_a = '0; m_b = '0;
        end else begin
            bit bat_now, off_now;
            int want;
            bat_now = bhi ? 1'b0 : (blo ? 1'b1 : m_bat);
            off_now = !sup || (m_lock && latch) || !bat_now || tf || !tsd_n;
            want    = latch ? m_held : int'(cmd);
            m_a     = off_now ? 10'h000 : mask_of(want, 1'b1);
            m_b     = off_now ? 10'h000 : mask_of(want, 1'b0);
            if (!sup)        begin m_held = 0; m_lock = 1; end
            else if (!latch) begin m_held = int'(cmd); m_lock = 0; end
            m_stat = !tf;
            m_bat  = bat_now;
        end
    end

    task automatic check_eq(input string req, input string what,
                            input logic [9:0] act, input logic [9:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check_eq(cur_req, "sw_en default", sw_a, m_a);
        check_eq(cur_req, "sw_en no-gen", sw_b, m_b);
        check_eq(cur_req, "therm_stat", {9'd0, stat_a}, {9'd0, m_stat});
        check_eq("R2", "legal mask", {9'd0, is_legal(sw_a) && is_legal(sw_b)}, 10'd1);
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R12", "reset sw_en", sw_a, 10'h000);
        check_eq("R12", "reset therm_stat", {9'd0, stat_a}, 10'd1);
        rst_n = 1'b1;
        tick(1);
        check_eq("R12", "post-reset sw_en", sw_a, 10'h000);

        // R7: supply up, latch held high -> stays off
        cur_req = "R7";
        sup = 1; blo = 1; cmd = 3'd1; tick(1); blo = 0;
        tick(3);
        check_eq("R7", "lockout while latch high", sw_a, 10'h000);

        // R1 / R11: sweep codes with latch open
        cur_req = "R1";
        latch = 0;
        for (int c = 0; c < 8; c++) begin
            cmd = 3'(c); tick(1);
            check_eq("R1", "decode", sw_a, mask_of(c, 1'b1));
            check_eq("R11", "decode no-gen", sw_b, mask_of(c, 1'b0));
        end

        // R3: transparent changes
        cur_req = "R3";
        cmd = 3'd2; tick(1); cmd = 3'd5; tick(1);
        check_eq("R3", "transparent follow", sw_a, 10'h330);

        // R4: hold
        cur_req = "R4";
        cmd = 3'd1; tick(1);
        latch = 1; cmd = 3'd4; tick(1);
        cmd = 3'd6; tick(2);
        check_eq("R4", "held command", sw_a, 10'h003);

        // R5: thermal fault over held latch
        cur_req = "R5";
        tf = 1; tick(1);
        check_eq("R5", "thermal off", sw_a, 10'h000);
        check_eq("R10", "therm_stat low", {9'd0, stat_a}, 10'd0);
        tick(2); tf = 0; tick(1);
        check_eq("R5", "thermal release", sw_a, 10'h003);

        // R6 / R10: external pin
        cur_req = "R6";
        tsd_n = 0; tick(1);
        check_eq("R6", "pin off", sw_a, 10'h000);
        check_eq("R10", "pin leaves status", {9'd0, stat_a}, 10'd1);
        tsd_n = 1; tick(1);

        // R9: battery hysteresis
        cur_req = "R9";
        bhi = 1; tick(1); bhi = 0; tick(3);
        check_eq("R9", "battery kept lost", sw_a, 10'h000);
        blo = 1; bhi = 1; tick(1);
        check_eq("R9", "both flags -> lost", sw_a, 10'h000);
        bhi = 0; tick(1); blo = 0; tick(1);
        check_eq("R9", "battery restored", sw_a, 10'h003);

        // R7: supply drop, recover with latch high
        cur_req = "R7";
        sup = 0; tick(2); sup = 1; cmd = 3'd3; tick(3);
        check_eq("R7", "off until latch low", sw_a, 10'h000);
        latch = 0; tick(1);
        check_eq("R7", "release on latch low", sw_a, 10'h030);

        // R8: recover with latch already low
        cur_req = "R8";
        sup = 0; tick(2); cmd = 3'd2; sup = 1; tick(1);
        check_eq("R8", "straight to command", sw_a, 10'h00C);

        // Random mix, R2 legality every cycle
        cur_req = "R2";
        for (int i = 0; i < 2000; i++) begin
            cmd   = 3'($urandom_range(0, 7));
            latch = ($urandom_range(0, 3) == 0);
            sup   = ($urandom_range(0, 40) != 0);
            bhi   = ($urandom_range(0, 60) == 0);
            blo   = ($urandom_range(0, 4) == 0);
            tf    = ($urandom_range(0, 30) == 0);
            tsd_n = ($urandom_range(0, 30) != 0);
            tick(1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule